// File: doc/BRIEF.md
# Masked Alarm Compare and Interrupt Router

This block sits beside the timekeeping counters of a real-time clock. It holds no time of its own. On each once-per-second update strobe it compares the current BCD time against two alarm settings. Each alarm field has a mask bit, so the same hardware yields repeat rates from once per second up to a full day-and-time match. The alarm day/date byte can target either the day of the week or the date of the month.

A match sets a sticky flag. Software clears a flag by writing a zero to it. The flags are routed to two active-low interrupt lines under the control of a routing mode bit. In one mode each alarm owns its own line. In the other mode the second line carries a square wave, picked from four prescaler taps, and only alarm 2 can interrupt, on the first line.

The control and status register contents arrive as inputs. The block registers only the two flags and the two output levels.

Top module: `alarm_irq_router`

## Requirements
- R1: After reset both flags read 0 and both `irq_a_n` and `sqw_irq_b_n` are high.
- R2: Alarm 1 masks sit in bit 7 of its seconds, minutes, hours and day/date bytes. Written as {day/date, hours, minutes, seconds}, the patterns behave as follows. 1111 fires on every update. 1110 needs seconds equal. 1100 adds minutes. 1000 adds hours. 0000 also needs day/date. A fire sets `a1_flag` at the clock edge that ends the strobe cycle.
- R3: Alarm 2 has no seconds byte and fires only when the time's seconds are 00. Its masks sit in bit 7 of its minutes, hours and day/date bytes. Written as {day/date, hours, minutes}: 111 fires at every minute, 110 adds minutes, 100 adds hours, and 000 adds day/date.
- R4: Bit 6 of an alarm day/date byte selects the target. A 0 compares its bits 5:0 with the date of the month, and a 1 compares them with the day of the week.
- R5: Hours compare on bits 6:0, including the 12/24 mode bit (bit 6) and the AM/PM bit (bit 5). An alarm written in the other hour mode never matches.
- R6: Without the update strobe no flag is set, even when the time matches.
- R7: With `flag_wr`, a 0 in `flag_wdata` bit 0 (alarm 1) or bit 1 (alarm 2) clears that flag, and a 1 leaves it unchanged. A match in the same cycle wins over the clear.
- R8: With `ctrl_intcn`=1, alarm 1 flag AND `ctrl_a1ie` drives `irq_a_n` low, and alarm 2 flag AND `ctrl_a2ie` drives `sqw_irq_b_n` low.
- R9: With `ctrl_intcn`=0, alarm 2 flag AND `ctrl_a2ie` drives `irq_a_n` low, and alarm 1 drives neither line.
- R10: With `ctrl_intcn`=0, `sqw_irq_b_n` follows `osc_taps[ctrl_rate]` one clock later. The rate codes are 0 = 1 Hz, 1 = 4.096 kHz, 2 = 8.192 kHz and 3 = 32.768 kHz.
- R11: Both outputs are registered. They change at the same edge as the flags that drive them, and one edge after a control change. A line stays low while its flag and enable hold, and releases at the edge that clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | Once-per-second update strobe, time vector valid |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours with mode and AM/PM bits |
| tm_wday | input | 8 | Current day of week |
| tm_mday | input | 8 | Current date of month, BCD |
| al1_sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| al1_min | input | 8 | Alarm 1 minutes, bit 7 mask |
| al1_hour | input | 8 | Alarm 1 hours, bit 7 mask |
| al1_dd | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 select |
| al2_min | input | 8 | Alarm 2 minutes, bit 7 mask |
| al2_hour | input | 8 | Alarm 2 hours, bit 7 mask |
| al2_dd | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 select |
| ctrl_rate | input | 2 | Square-wave rate select |
| ctrl_intcn | input | 1 | Routing mode: 1 separate lines, 0 square wave on line B |
| ctrl_a2ie | input | 1 | Alarm 2 interrupt enable |
| ctrl_a1ie | input | 1 | Alarm 1 interrupt enable |
| flag_wr | input | 1 | Status write strobe |
| flag_wdata | input | 2 | Status write data: bit 1 alarm 2, bit 0 alarm 1 |
| osc_taps | input | 4 | Prescaler square waves indexed by rate code |
| a1_flag | output | 1 | Alarm 1 sticky flag |
| a2_flag | output | 1 | Alarm 2 sticky flag |
| irq_a_n | output | 1 | Interrupt line A, active low |
| sqw_irq_b_n | output | 1 | Square wave or interrupt line B, active low |

## Verification
Every result is due exactly one clock edge after its stimulus. A strobe sets its flag at the edge that closes the strobe cycle, and the outputs move at that same edge. A clear write, an enable or mode change, or a tap change also takes effect after one edge. The bench drives all inputs on the falling edge and samples on the next falling edge, so each check sits one rising edge after its cause. Before each match check the bench clears both flags and lets one edge pass, so no earlier hit can mask the result.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int FIELD_W  = 8;
    localparam int MASK_BIT = 7;
    localparam int SEL_BIT  = 6;

    typedef struct packed {
        logic a1f;
        logic a2f;
        logic irq_a_n;
        logic irq_b_n;
    } rtr_state_t;

    localparam rtr_state_t RTR_RESET = '{a1f: 1'b0, a2f: 1'b0, irq_a_n: 1'b1, irq_b_n: 1'b1};
endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alm_pkg::*;
(
    input  logic [FIELD_W-1:0] tm_sec,
    input  logic [FIELD_W-1:0] tm_min,
    input  logic [FIELD_W-1:0] tm_hour,
    input  logic [FIELD_W-1:0] tm_wday,
    input  logic [FIELD_W-1:0] tm_mday,
    input  logic [FIELD_W-1:0] al_sec,
    input  logic [FIELD_W-1:0] al_min,
    input  logic [FIELD_W-1:0] al_hour,
    input  logic [FIELD_W-1:0] al_dd,
    output logic               hit
);
    logic [FIELD_W-1:0] dd_target;
    logic sec_ok, min_ok, hour_ok, dd_ok;

    always_comb begin
        dd_target = al_dd[SEL_BIT] ? tm_wday : tm_mday;
        sec_ok  = al_sec[MASK_BIT]  || (tm_sec  == {1'b0, al_sec[MASK_BIT-1:0]});
        min_ok  = al_min[MASK_BIT]  || (tm_min  == {1'b0, al_min[MASK_BIT-1:0]});
        hour_ok = al_hour[MASK_BIT] || (tm_hour == {1'b0, al_hour[MASK_BIT-1:0]});
        dd_ok   = al_dd[MASK_BIT]   || (dd_target == {2'b00, al_dd[SEL_BIT-1:0]});
        hit     = sec_ok && min_ok && hour_ok && dd_ok;
    end
endmodule

// File: rtl/sqw_select.sv
module sqw_select #(
    parameter int RATE_W = 2,
    localparam int NUM_TAPS = 1 << RATE_W
) (
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [RATE_W-1:0]   rate,
    output logic                wave
);
    always_comb wave = taps[rate];
endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
    import alm_pkg::*;
#(
    parameter int RATE_W = 2,
    localparam int NUM_TAPS = 1 << RATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FIELD_W-1:0] tm_sec,
    input  logic [FIELD_W-1:0] tm_min,
    input  logic [FIELD_W-1:0] tm_hour,
    input  logic [FIELD_W-1:0] tm_wday,
    input  logic [FIELD_W-1:0] tm_mday,
    input  logic [FIELD_W-1:0] al1_sec,
    input  logic [FIELD_W-1:0] al1_min,
    input  logic [FIELD_W-1:0] al1_hour,
    input  logic [FIELD_W-1:0] al1_dd,
    input  logic [FIELD_W-1:0] al2_min,
    input  logic [FIELD_W-1:0] al2_hour,
    input  logic [FIELD_W-1:0] al2_dd,
    input  logic [RATE_W-1:0]  ctrl_rate,
    input  logic               ctrl_intcn,
    input  logic               ctrl_a2ie,
    input  logic               ctrl_a1ie,
    input  logic               flag_wr,
    input  logic [1:0]         flag_wdata,
    input  logic [NUM_TAPS-1:0] osc_taps,
    output logic               a1_flag,
    output logic               a2_flag,
    output logic               irq_a_n,
    output logic               sqw_irq_b_n
);
    rtr_state_t st_d, st_q;
    logic a1_hit, a2_hit, sel_tap;

    alarm_match u_match1 (
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_wday(tm_wday), .tm_mday(tm_mday),
        .al_sec(al1_sec), .al_min(al1_min), .al_hour(al1_hour), .al_dd(al1_dd),
        .hit(a1_hit)
    );

    // Alarm 2 has no seconds byte: an unmasked zero pins it to second 00.
    alarm_match u_match2 (
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_wday(tm_wday), .tm_mday(tm_mday),
        .al_sec('0), .al_min(al2_min), .al_hour(al2_hour), .al_dd(al2_dd),
        .hit(a2_hit)
    );

    sqw_select #(.RATE_W(RATE_W)) u_sqw (
        .taps(osc_taps), .rate(ctrl_rate), .wave(sel_tap)
    );

    always_comb begin
        st_d = st_q;
        st_d.a1f = (sec_tick && a1_hit) || (st_q.a1f && !(flag_wr && !flag_wdata[0]));
        st_d.a2f = (sec_tick && a2_hit) || (st_q.a2f && !(flag_wr && !flag_wdata[1]));
        if (ctrl_intcn) begin
            st_d.irq_a_n = !(st_d.a1f && ctrl_a1ie);
            st_d.irq_b_n = !(st_d.a2f && ctrl_a2ie);
        end else begin
            st_d.irq_a_n = !(st_d.a2f && ctrl_a2ie);
            st_d.irq_b_n = sel_tap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RTR_RESET;
        else        st_q <= st_d;
    end

    assign a1_flag     = st_q.a1f;
    assign a2_flag     = st_q.a2f;
    assign irq_a_n     = st_q.irq_a_n;
    assign sqw_irq_b_n = st_q.irq_b_n;

    // R6
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !a1_flag) |=> !a1_flag);
    // R7
    wr_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[0] && a1_flag) |=> a1_flag);
    // R7
    wr_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata[1] && !sec_tick) |=> !a2_flag);
    // R9
    a1_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_intcn && !ctrl_a2ie) |=> irq_a_n);
    // R10
    sqw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_intcn |=> (sqw_irq_b_n == $past(sel_tap)));
    // R8
    b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_intcn && !ctrl_a2ie) |=> sqw_irq_b_n);
endmodule

// File: tb/tb_alarm_irq_router.sv
module tb_alarm_irq_router;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
    logic [7:0] tm_sec = 0, tm_min = 0, tm_hour = 0, tm_wday = 0, tm_mday = 0;
    logic [7:0] al1_sec = 8'h80, al1_min = 8'h80, al1_hour = 8'h80, al1_dd = 8'h80;
    logic [7:0] al2_min = 8'h80, al2_hour = 8'h80, al2_dd = 8'h80;
    logic [1:0] ctrl_rate = 2'b11, flag_wdata = 2'b00;
    logic ctrl_intcn = 1'b0, ctrl_a2ie = 1'b0, ctrl_a1ie = 1'b0, flag_wr = 1'b0;
    logic [3:0] osc_taps = 4'hF;
    logic a1_flag, a2_flag, irq_a_n, sqw_irq_b_n;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_router dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clr_flags();
        @(negedge clk); flag_wr = 1'b1; flag_wdata = 2'b00;
        @(negedge clk); flag_wr = 1'b0;
    endtask

    task automatic tick(input logic [7:0] s, m, h, wd, md);
        @(negedge clk);
        tm_sec = s; tm_min = m; tm_hour = h; tm_wday = wd; tm_mday = md; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] m1pat [5];
        logic [2:0] m2pat [4];
        m1pat = '{4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000};
        m2pat = '{3'b111, 3'b110, 3'b100, 3'b000};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 a1_flag", {7'b0, a1_flag}, 8'h00);
        chk("R1 a2_flag", {7'b0, a2_flag}, 8'h00);
        chk("R1 irq_a_n", {7'b0, irq_a_n}, 8'h01);
        chk("R1 sqw_irq_b_n", {7'b0, sqw_irq_b_n}, 8'h01);
        rst_n = 1'b1;

        // R2 alarm 1 mask sweep: 5 patterns x 16 field-equality combos
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic exp;
                al1_sec = {m1pat[p][0], 7'h30}; al1_min = {m1pat[p][1], 7'h15};
                al1_hour = {m1pat[p][2], 7'h08}; al1_dd = {m1pat[p][3], 7'h12};
                exp = (m1pat[p][0] | c[0]) & (m1pat[p][1] | c[1]) & (m1pat[p][2] | c[2]) & (m1pat[p][3] | c[3]);
                clr_flags();
                tick(c[0] ? 8'h30 : 8'h31, c[1] ? 8'h15 : 8'h16, c[2] ? 8'h08 : 8'h09, 8'h02, c[3] ? 8'h12 : 8'h13);
                chk("R2 a1 mask", {7'b0, a1_flag}, {7'b0, exp});
            end
        end

        // R3 alarm 2 mask sweep: 4 patterns x 16 combos (c[0] = seconds 00)
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic exp;
                al2_min = {m2pat[p][0], 7'h45}; al2_hour = {m2pat[p][1], 7'h21}; al2_dd = {m2pat[p][2], 7'h27};
                exp = c[0] & (m2pat[p][0] | c[1]) & (m2pat[p][1] | c[2]) & (m2pat[p][2] | c[3]);
                clr_flags();
                tick(c[0] ? 8'h00 : 8'h30, c[1] ? 8'h45 : 8'h44, c[2] ? 8'h21 : 8'h20, 8'h05, c[3] ? 8'h27 : 8'h28);
                chk("R3 a2 mask", {7'b0, a2_flag}, {7'b0, exp});
            end
        end

        // R4 day/date select on alarm 1 (full match)
        al1_sec = 8'h10; al1_min = 8'h20; al1_hour = 8'h11;
        al1_dd = 8'h43; clr_flags(); tick(8'h10, 8'h20, 8'h11, 8'h03, 8'h05);
        chk("R4 day match", {7'b0, a1_flag}, 8'h01);
        clr_flags(); tick(8'h10, 8'h20, 8'h11, 8'h05, 8'h03);
        chk("R4 day vs date", {7'b0, a1_flag}, 8'h00);
        al1_dd = 8'h03; clr_flags(); tick(8'h10, 8'h20, 8'h11, 8'h05, 8'h03);
        chk("R4 date match", {7'b0, a1_flag}, 8'h01);
        clr_flags(); tick(8'h10, 8'h20, 8'h11, 8'h03, 8'h05);
        chk("R4 date vs day", {7'b0, a1_flag}, 8'h00);

        // R5 hour mode bits take part in the compare
        al1_dd = 8'h80; al1_hour = 8'h48;
        clr_flags(); tick(8'h10, 8'h20, 8'h08, 8'h01, 8'h01);
        chk("R5 12h vs 24h", {7'b0, a1_flag}, 8'h00);
        clr_flags(); tick(8'h10, 8'h20, 8'h68, 8'h01, 8'h01);
        chk("R5 AM vs PM", {7'b0, a1_flag}, 8'h00);
        clr_flags(); tick(8'h10, 8'h20, 8'h48, 8'h01, 8'h01);
        chk("R5 same mode", {7'b0, a1_flag}, 8'h01);

        // R6 matching time without strobe
        al1_sec = 8'h80; al1_min = 8'h80; al1_hour = 8'h80;
        clr_flags();
        repeat (4) @(negedge clk);
        chk("R6 no strobe", {7'b0, a1_flag}, 8'h00);

        // R7 write semantics; alarm 1 fires at sec 59, alarm 2 at sec 00
        al1_sec = 8'h59; al1_min = 8'h80; al1_hour = 8'h80; al1_dd = 8'h80;
        al2_min = 8'h80; al2_hour = 8'h80; al2_dd = 8'h80;
        tick(8'h59, 0, 0, 1, 1); tick(8'h00, 0, 0, 1, 1);
        chk("R7 both set", {6'b0, a2_flag, a1_flag}, 8'h03);
        @(negedge clk); flag_wr = 1'b1; flag_wdata = 2'b11;
        @(negedge clk); flag_wr = 1'b0;
        chk("R7 write ones keep", {6'b0, a2_flag, a1_flag}, 8'h03);
        flag_wr = 1'b1; flag_wdata = 2'b10;
        @(negedge clk); flag_wr = 1'b0;
        chk("R7 clear a1 only", {6'b0, a2_flag, a1_flag}, 8'h02);
        flag_wr = 1'b1; flag_wdata = 2'b00;
        tm_sec = 8'h59; sec_tick = 1'b1;
        @(negedge clk); flag_wr = 1'b0; sec_tick = 1'b0;
        chk("R7 set beats clear", {6'b0, a2_flag, a1_flag}, 8'h01);

        // R8 R9 R11 routing over mode x enables x flags
        osc_taps = 4'b0110; ctrl_rate = 2'd2;
        for (int c = 0; c < 32; c++) begin
            logic ea, eb;
            clr_flags();
            if (c[3]) tick(8'h59, 0, 0, 1, 1);
            if (c[4]) tick(8'h00, 0, 0, 1, 1);
            @(negedge clk); ctrl_intcn = c[0]; ctrl_a1ie = c[1]; ctrl_a2ie = c[2];
            @(negedge clk);
            ea = c[0] ? !(c[3] & c[1]) : !(c[4] & c[2]);
            eb = c[0] ? !(c[4] & c[2]) : osc_taps[ctrl_rate];
            chk(c[0] ? "R8 irq_a_n" : "R9 irq_a_n", {7'b0, irq_a_n}, {7'b0, ea});
            chk(c[0] ? "R8 sqw_irq_b_n" : "R10 sqw_irq_b_n", {7'b0, sqw_irq_b_n}, {7'b0, eb});
        end

        // R11 release at the edge that clears the flag
        ctrl_intcn = 1'b1; ctrl_a1ie = 1'b1; ctrl_a2ie = 1'b1;
        clr_flags(); tick(8'h59, 0, 0, 1, 1);
        chk("R11 low with flag", {7'b0, irq_a_n}, 8'h00);
        flag_wr = 1'b1; flag_wdata = 2'b10;
        @(negedge clk); flag_wr = 1'b0;
        chk("R11 release", {6'b0, a1_flag, irq_a_n}, 8'h01);

        // R10 rate select sweep, all taps and codes
        ctrl_intcn = 1'b0;
        for (int t = 0; t < 16; t++) begin
            for (int r = 0; r < 4; r++) begin
                osc_taps = t[3:0]; ctrl_rate = r[1:0];
                @(negedge clk);
                chk("R10 rate tap", {7'b0, sqw_irq_b_n}, {7'b0, t[r]});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule